// File: doc/BRIEF.md
# Instruction Prefetch Stream Buffer

This block sits between a first-level instruction cache and a slow burst-capable memory. It holds four 32-bit instruction words as two halves of one 64-bit pair each. Every half carries its own pair-address tag and valid bit. When the cache raises a request, the pair address is compared against both tags at the same time. A matching half goes straight back to the cache in the same cycle, so a cache miss that hits here costs one cycle.

On a miss the block starts a two-beat burst at the four-word block that contains the requested pair. Each low dip of the memory's wait line marks one arriving beat. The first dip fills the lower half and the second dip fills the upper half. The stall line toward the cache stays high for the whole fill, so the cache never sees the dips between beats.

Misses come from three situations. One is the empty buffer after reset. Another is a branch target that is not held. The last is a sequential walk that runs past the block already held. All three are handled by the same miss rule.

Top module: `ifetch_prefetch_buf`

## Requirements
- R1: During and right after reset, `mem_req` is low, and no half is valid, so the first request after reset misses.
- R2: A request whose pair address matches a valid half returns that half in the same cycle with `cache_stall` low. Bits [31:0] hold the even word of the pair and bits [63:32] the odd word.
- R3: A request that matches no valid half raises `cache_stall` in the same cycle. In the next cycle `mem_req` rises with `mem_addr` equal to the requested pair address with bit 0 cleared.
- R4: With `cache_req` low, `cache_stall` is low, and `mem_req` is low whenever no fill is in progress.
- R5: While a fill is in progress, `cache_stall` is high in every cycle in which `cache_req` is high, whatever `mem_wait` does.
- R6: During a fill, the first cycle with `mem_wait` low writes `mem_data` into the half tagged with the block base. The second such cycle writes the half tagged with base+1. `mem_req` falls in the cycle after the second low cycle.
- R7: `mem_addr` is even and does not change while `mem_req` is high.
- R8: Low cycles of `mem_wait` while no fill is in progress change no stored half, tag or valid bit.
- R9: After two hits inside the held block, a request for the next sequential pair outside it misses and starts a new burst. A request to an absent branch target does the same.
- R10: Starting a burst drops the block held before, so after the fill a request to the old block misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_req | input | 1 | Cache asks for an instruction pair |
| cache_addr | input | ADDR_W | Pair address requested by the cache |
| cache_stall | output | 1 | High while the requested pair is not yet available |
| cache_data | output | 2*WORD_W | Requested pair, even word in the low half |
| mem_req | output | 1 | Burst request to memory, high for the whole fill |
| mem_addr | output | ADDR_W | Even pair address where the burst starts |
| mem_wait | input | 1 | Memory wait line; a low cycle marks a valid beat |
| mem_data | input | 2*WORD_W | Beat data from memory |

## Verification
The bench builds the block with its defaults: a 10-bit pair address and 32-bit words. At these sizes the whole address space is reachable, including the top block at pairs 0x3FE/0x3FF. The bench's memory model varies the gap between the two dips from zero to two cycles, so back-to-back beats and spread beats both occur. It also drops stray low cycles on the wait line between bursts. Sequential walks that cross block edges are mixed with random jumps.

// File: rtl/ifetch_prefetch_buf.sv
module ifetch_prefetch_buf #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cache_req,
  input  logic [ADDR_W-1:0]     cache_addr,
  output logic                  cache_stall,
  output logic [2*WORD_W-1:0]   cache_data,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_wait,
  input  logic [2*WORD_W-1:0]   mem_data
);
  localparam int LINE_W = 2 * WORD_W;
  localparam int HALVES = 2;

  logic                busy_q;
  logic                beat_q;
  logic [ADDR_W-1:0]   base_q;
  logic [HALVES-1:0]   vld_q;
  logic [ADDR_W-1:0]   tag_q  [HALVES];
  logic [LINE_W-1:0]   line_q [HALVES];
  logic [HALVES-1:0]   match;

  for (genvar h = 0; h < HALVES; h++) begin : g_cmp
    assign match[h] = vld_q[h] && (tag_q[h] == cache_addr);
  end

  wire hit   = |match;
  wire start = cache_req && !busy_q && !hit;
  wire take  = busy_q && !mem_wait;

  assign cache_data  = match[1] ? line_q[1] : line_q[0];
  assign cache_stall = cache_req && (busy_q || !hit);
  assign mem_req     = busy_q;
  assign mem_addr    = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= 1'b0;
      vld_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      beat_q <= 1'b0;
      vld_q  <= '0;
      base_q <= {cache_addr[ADDR_W-1:1], 1'b0};
    end else if (take) begin
      vld_q[beat_q] <= 1'b1;
      beat_q        <= ~beat_q;
      if (beat_q) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      line_q[beat_q] <= mem_data;
      tag_q[beat_q]  <= {base_q[ADDR_W-1:1], beat_q};
    end
  end
endmodule

// File: rtl/ifetch_prefetch_buf_chk.sv
module ifetch_prefetch_buf_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_req,
  input logic              cache_stall,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wait
);
  logic [1:0] dips;
  always_ff @(posedge clk) begin
    if (!rst_n || !mem_req) dips <= '0;
    else if (!mem_wait && dips != 2'd3) dips <= dips + 2'd1;
  end

  // R4
  no_req_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_req |-> !cache_stall);
  // R5
  fill_masks_dips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cache_req) |-> cache_stall);
  // R3
  miss_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req && cache_stall && !mem_req) |=> mem_req);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));
  // R7
  addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
  // R6
  fill_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_wait && dips == 2'd1) |=> !mem_req);
endmodule

bind ifetch_prefetch_buf ifetch_prefetch_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_req(cache_req), .cache_stall(cache_stall),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_wait(mem_wait));

// File: tb/sim_ifetch_prefetch_buf.sv
module sim_ifetch_prefetch_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WW = 32;
  localparam int LAT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cache_req = 1'b0;
  logic [AW-1:0] cache_addr = '0;
  logic cache_stall, mem_req;
  logic [2*WW-1:0] cache_data, mem_data;
  logic [AW-1:0] mem_addr;
  logic mem_wait;

  int tests = 0, fails = 0, nbursts = 0, cycles = 0;
  logic [AW-1:0] exp_base = '0;
  logic [1:0] m_vld = '0;
  logic [AW-1:0] m_tag [2];
  bit in_burst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_prefetch_buf #(.ADDR_W(AW), .WORD_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .cache_req(cache_req), .cache_addr(cache_addr),
    .cache_stall(cache_stall), .cache_data(cache_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wait(mem_wait), .mem_data(mem_data));

  function automatic logic [WW-1:0] word_of(logic [AW-1:0] p, bit k);
    return (32'h9E3779B9 * ({21'b0, p, k} + 32'd1)) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [2*WW-1:0] pair_of(logic [AW-1:0] p);
    return {word_of(p, 1'b1), word_of(p, 1'b0)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic burst();
    logic [AW-1:0] b;
    int gap;
    in_burst = 1'b1;
    b = mem_addr;
    mem_wait = 1'b1;
    chk(b == exp_base, "R3 burst address", 64'(b), 64'(exp_base));
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == b, "R7 address held", 64'(mem_addr), 64'(b));
    end
    mem_wait = 1'b0; mem_data = pair_of(b);
    gap = int'($urandom_range(0, 2));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); mem_wait = 1'b1; mem_data = '1;
    end
    @(negedge clk);
    mem_wait = 1'b0; mem_data = pair_of(b | 1);
    @(negedge clk);
    mem_wait = 1'b1;
    chk(!mem_req, "R6 request falls after second dip", 64'(mem_req), 64'd0);
    nbursts++;
    in_burst = 1'b0;
  endtask

  initial begin
    mem_wait = 1'b1; mem_data = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (mem_req) burst();
      else if ($urandom_range(0, 7) == 0) begin
        mem_wait = 1'b0; mem_data = {$urandom, $urandom};
      end else mem_wait = 1'b1;
    end
  end

  task automatic fetch(logic [AW-1:0] p, string req);
    bit exp_hit;
    int nb0, n;
    exp_hit = (m_vld[0] && m_tag[0] == p) || (m_vld[1] && m_tag[1] == p);
    if (!exp_hit) exp_base = {p[AW-1:1], 1'b0};
    nb0 = nbursts;
    @(negedge clk);
    cache_req = 1'b1; cache_addr = p;
    #1;
    chk(cache_stall == !exp_hit, exp_hit ? "R2 hit no stall" : "R3 miss stalls",
        64'(cache_stall), 64'(!exp_hit));
    n = 0;
    while (cache_stall && n < 100) begin
      @(negedge clk); #1; n++;
    end
    chk(cache_data == pair_of(p), {req, " data"}, cache_data, pair_of(p));
    chk(nbursts == nb0 + (exp_hit ? 0 : 1), {req, " burst count"},
        64'(nbursts - nb0), 64'(exp_hit ? 0 : 1));
    if (!exp_hit) begin
      m_vld = 2'b11; m_tag[0] = exp_base; m_tag[1] = exp_base | 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cache_req = 1'b0; #1;
      chk(!cache_stall, "R4 no request no stall", 64'(cache_stall), 64'd0);
      if (!in_burst) chk(!mem_req, "R4 no request no fill", 64'(mem_req), 64'd0);
    end
  endtask

  initial begin
    logic [AW-1:0] p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!mem_req && !cache_stall, "R1 reset outputs", 64'({mem_req, cache_stall}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty after reset
    fetch(10'h040, "R1 first request misses");
    fetch(10'h040, "R2 repeat hit");
    fetch(10'h041, "R6 upper half");
    // R9 sequential walk past the block
    fetch(10'h042, "R9 sequential miss");
    // R8 stray dips while idle
    idle(30);
    fetch(10'h043, "R8 survives stray dips");
    fetch(10'h042, "R8 lower intact");
    // R9 branch target, top of space
    fetch(10'h3FF, "R9 branch miss");
    fetch(10'h3FE, "R6 lower half of top block");
    // R10 old block dropped
    fetch(10'h042, "R10 old block misses");
    p = 10'h100;
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 4) == 0) p = AW'($urandom);
      else p = p + 1;
      fetch(p, "R2 random");
      idle(int'($urandom_range(0, 2)));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule